// File: doc/BRIEF.md
# MDIO Management Master

This block is the master end of a two-wire PHY management bus. It produces the management clock from the system clock and drives or releases the shared data line to read and write PHY registers. A host presents one request: an operation (short-form read, short-form write, extended read or extended write), a 5-bit PHY address, a 5-bit register or device field, a 16-bit extended register address and 16 bits of write data. When the transaction ends, the block returns the read data, a one-cycle completion pulse and a flag that reports a missing PHY.

Every frame starts with a preamble of ones. The 14-bit header follows: start, opcode, PHY, register. Then come a turnaround and 16 data bits, and the frame ends with one clock on which the line is released. An extended access goes out as two frames back to back, with nothing more needed from the host. The first is an address frame that carries the 16-bit register address as data. The second is the read or write frame. On reads, the block checks the turnaround bit the PHY returns. When no PHY answers, it clocks out the PHY's possible transfer and reports all-ones. A per-PHY mask can switch this check off for a PHY whose turnaround is known to be faulty.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Every frame begins with 32 clock slots in which the data line is driven (`mdio_oe`=1) to 1.
- R2: A short-form frame sends start 0,1 followed by a 2-bit opcode. When `cfg_op_ovr`=0 the opcode is 1,0 for a read and 0,1 for a write. When `cfg_op_ovr`=1 it is `cfg_c22_rd_op` or `cfg_c22_wr_op`. Each field goes out MSB first.
- R3: An extended request (`req_op` 2 = read, 3 = write) produces an address frame followed by an access frame. The address frame has start 0,0, opcode 0,0, the device field in the register slot and `req_c45_addr` as data. The access frame has start 0,0 and opcode 1,1 for a read or 0,1 for a write.
- R4: After the opcode, the PHY address (5 bits) and then the register/device field (5 bits) are sent MSB first.
- R5: Write and address frames drive turnaround 1,0 and then 16 data bits MSB first. One released slot follows, so a frame has 65 slots.
- R6: A read frame releases the line after the 14 header bits. It samples the turnaround in slot 46 and 16 data bits MSB first in slots 47 to 62, then spends one more idle slot (64 slots in all). `rsp_data` returns the data with `rsp_ta_err`=0.
- R7: If the sampled turnaround is 1 and bit `phy` of `cfg_ta_ignore` is 0, the block clocks 32 more slots without using them (79 slots). It then returns `rsp_data`=16'hFFFF with `rsp_ta_err`=1.
- R8: If bit `phy` of `cfg_ta_ignore` is 1, a turnaround of 1 is ignored and the read completes as in R6.
- R9: Each MDC half period lasts exactly `cfg_half_div` system clocks (0 is treated as 1). The data line changes only while MDC is low, and MDC stays low with the line released while the block is idle.
- R10: A request is taken only while `req_ready`=1, and requests presented while busy are ignored. Every accepted request yields exactly one `rsp_done` pulse of one system clock, and `req_ready` is high again in that cycle.
- R11: Codes of `req_op` are 0 = short read, 1 = short write, 2 = extended read, 3 = extended write. Bit 1 selects the extended form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, request will be taken |
| req_op | input | 2 | Operation code (R11) |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register (short) or device (extended) field |
| req_c45_addr | input | 16 | Extended register address |
| req_wdata | input | 16 | Write data |
| cfg_half_div | input | DIV_W | System clocks per MDC half period |
| cfg_op_ovr | input | 1 | Use configured short-form opcodes |
| cfg_c22_rd_op | input | 2 | Short-form read opcode when overridden |
| cfg_c22_wr_op | input | 2 | Short-form write opcode when overridden |
| cfg_ta_ignore | input | 32 | Per-PHY turnaround-check disable |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |
| rsp_data | output | 16 | Read result |
| rsp_done | output | 1 | Transaction complete pulse |
| rsp_ta_err | output | 1 | Turnaround missing on last read |

## Verification
Two events can fall in the same system clock, and both are provoked. The first is the falling MDC edge that closes the last slot of a frame. It can coincide with the load of the second frame of an extended access, or with the completion pulse together with the return to idle. Extended requests with random divider values, half periods of one clock among them, make these collisions happen. The bench judges them by recording the driven bits at every rising MDC edge against a bench-built frame image. It also checks the slot count, the half-period lengths and that MDC is low and the line is released once done is seen. The second event is a new request that arrives while a frame runs. The bench raises `req_valid` with different fields during a busy period and checks that the frame image and the single done pulse are unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    OP_SHORT_RD = 2'd0,
    OP_SHORT_WR = 2'd1,
    OP_EXT_RD   = 2'd2,
    OP_EXT_WR   = 2'd3
  } mdio_op_e;

  localparam int PRE_N    = 32;
  localparam int HDR_N    = 14;
  localparam int DATA_N   = 16;
  localparam int WORD_N   = PRE_N + HDR_N + 2 + DATA_N;
  localparam int TA_SLOT  = PRE_N + HDR_N;
  localparam int DRV_LAST = WORD_N;
  localparam int RD_LAST  = TA_SLOT + DATA_N + 1;
  localparam int FL_LAST  = TA_SLOT + 32;
  localparam int IDX_W    = $clog2(FL_LAST + 1);
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             bit_end
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_m1;

  assign half_m1 = (half == '0) ? '0 : half - 1'b1;
  assign bit_end = run && mdc && (cnt >= half_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt >= half_m1) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: while running, a falling MDC edge only ever closes a full high phase
  p_fall_closes_slot_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(mdc) && $past(run)) |-> $past(bit_end));
endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= word;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int         DIV_W      = 8,
  parameter logic [1:0] C22_RD_DEF = 2'b10,
  parameter logic [1:0] C22_WR_DEF = 2'b01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [4:0]       req_phy,
  input  logic [4:0]       req_reg,
  input  logic [15:0]      req_c45_addr,
  input  logic [15:0]      req_wdata,
  input  logic [DIV_W-1:0] cfg_half_div,
  input  logic             cfg_op_ovr,
  input  logic [1:0]       cfg_c22_rd_op,
  input  logic [1:0]       cfg_c22_wr_op,
  input  logic [31:0]      cfg_ta_ignore,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i,
  output logic [15:0]      rsp_data,
  output logic             rsp_done,
  output logic             rsp_ta_err
);
  localparam logic [IDX_W-1:0] I_PRE  = IDX_W'(PRE_N);
  localparam logic [IDX_W-1:0] I_TA   = IDX_W'(TA_SLOT);
  localparam logic [IDX_W-1:0] I_DRV  = IDX_W'(DRV_LAST);
  localparam logic [IDX_W-1:0] I_RD   = IDX_W'(RD_LAST);
  localparam logic [IDX_W-1:0] I_FL   = IDX_W'(FL_LAST);
  localparam logic [IDX_W-1:0] I_DEND = IDX_W'(TA_SLOT + DATA_N);

  typedef enum logic {S_IDLE, S_RUN} st_e;

  st_e              st;
  logic [IDX_W-1:0] idx;
  logic             is_rd, pend, ta_err;
  logic [4:0]       phy_q, reg_q;
  logic [15:0]      wd_q, rx_q;
  logic [1:0]       acc_op;
  logic             bit_end, accept, last, ld;
  logic [WORD_N-1:0] ld_word;
  logic [1:0]       short_op;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign last      = is_rd ? (ta_err ? (idx == I_FL) : (idx == I_RD)) : (idx == I_DRV);
  assign mdio_oe   = (st == S_RUN) && (is_rd ? (idx < I_TA) : (idx < I_DRV));

  always_comb begin
    if (req_op[0]) short_op = cfg_op_ovr ? cfg_c22_wr_op : C22_WR_DEF;
    else           short_op = cfg_op_ovr ? cfg_c22_rd_op : C22_RD_DEF;
    ld = accept || ((st == S_RUN) && bit_end && last && pend);
    if (st == S_IDLE) begin
      if (req_op[1])
        ld_word = {{PRE_N{1'b1}}, 2'b00, 2'b00, req_phy, req_reg, 2'b10, req_c45_addr};
      else
        ld_word = {{PRE_N{1'b1}}, 2'b01, short_op, req_phy, req_reg, 2'b10, req_wdata};
    end else begin
      ld_word = {{PRE_N{1'b1}}, 2'b00, acc_op, phy_q, reg_q, 2'b10, wd_q};
    end
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) i_clk (
    .clk(clk), .rst(rst), .run(st == S_RUN), .half(cfg_half_div),
    .mdc(mdc), .bit_end(bit_end));

  mdio_tx_shift #(.W(WORD_N)) i_tx (
    .clk(clk), .rst(rst), .load(ld), .word(ld_word),
    .shift(bit_end), .msb(mdio_o));

  mdio_rx_shift #(.W(DATA_N)) i_rx (
    .clk(clk), .rst(rst), .clr(accept),
    .en(bit_end && is_rd && !ta_err && (idx > I_TA) && (idx <= I_DEND)),
    .din(mdio_i), .q(rx_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; idx <= '0; is_rd <= 1'b0; pend <= 1'b0; ta_err <= 1'b0;
      phy_q <= '0; reg_q <= '0; wd_q <= '0; acc_op <= '0;
      rsp_done <= 1'b0; rsp_data <= '0; rsp_ta_err <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          st     <= S_RUN;
          idx    <= '0;
          ta_err <= 1'b0;
          phy_q  <= req_phy;
          reg_q  <= req_reg;
          wd_q   <= req_wdata;
          pend   <= req_op[1];
          is_rd  <= (req_op == OP_SHORT_RD);
          acc_op <= (req_op == OP_EXT_RD) ? 2'b11 : 2'b01;
        end
      end else if (bit_end) begin
        if (last) begin
          if (pend) begin
            idx   <= '0;
            pend  <= 1'b0;
            is_rd <= (acc_op == 2'b11);
          end else begin
            st         <= S_IDLE;
            rsp_done   <= 1'b1;
            rsp_data   <= ta_err ? 16'hFFFF : rx_q;
            rsp_ta_err <= ta_err;
          end
        end else begin
          idx <= idx + 1'b1;
          if (is_rd && (idx == I_TA) && mdio_i && !cfg_ta_ignore[phy_q])
            ta_err <= 1'b1;
        end
      end
    end
  end

  // R9: quiet bus while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mdc && !mdio_oe));
  // R9: data and enable hold while MDC stays high
  p_hold_high_r9: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  // R1: preamble slots are driven ones
  p_preamble_r1: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && idx < I_PRE) |-> (mdio_oe && mdio_o));
  // R10: single-cycle completion pulse, back to idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  p_done_ready_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_ready);
  // R7: missing PHY reports all-ones
  p_err_ones_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_ta_err) |-> (rsp_data == 16'hFFFF));
endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [4:0]  req_phy = '0, req_reg = '0;
  logic [15:0] req_c45_addr = '0, req_wdata = '0;
  logic [7:0]  cfg_half_div = 8'd2;
  logic        cfg_op_ovr = 1'b0;
  logic [1:0]  cfg_c22_rd_op = 2'b10, cfg_c22_wr_op = 2'b01;
  logic [31:0] cfg_ta_ignore = '0;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;
  logic [15:0] rsp_data;
  logic        rsp_done, rsp_ta_err;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_phy(req_phy), .req_reg(req_reg),
    .req_c45_addr(req_c45_addr), .req_wdata(req_wdata),
    .cfg_half_div(cfg_half_div), .cfg_op_ovr(cfg_op_ovr),
    .cfg_c22_rd_op(cfg_c22_rd_op), .cfg_c22_wr_op(cfg_c22_wr_op),
    .cfg_ta_ignore(cfg_ta_ignore), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .rsp_data(rsp_data),
    .rsp_done(rsp_done), .rsp_ta_err(rsp_ta_err));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit exp_oe [0:159];
  bit exp_o  [0:159];
  bit cap_oe [0:159];
  bit cap_o  [0:159];
  int exp_n, slot, rd_base, done_cnt, half_bad, run_len;
  bit mon_en, mdc_prev, seen_edge, ta_val, got_err;
  logic [15:0] rd_val, got_data;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic bit phy_bit(input int s);
    int b = s - rd_base;
    if (rd_base < 0) return 1'b1;
    if (b == 46) return ta_val;
    if (b >= 47 && b <= 62) return rd_val[62-b];
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    if (mon_en) begin
      if (mdc != mdc_prev) begin
        if (seen_edge && run_len != ((cfg_half_div == 0) ? 1 : int'(cfg_half_div))) half_bad++;
        run_len = 1; seen_edge = 1;
      end else run_len++;
      if (mdc && !mdc_prev) begin
        if (slot < 160) begin cap_oe[slot] = mdio_oe; cap_o[slot] = mdio_o; end
        mdio_i = phy_bit(slot);
        slot++;
      end
      if (rsp_done) begin done_cnt++; got_data = rsp_data; got_err = rsp_ta_err; end
      mdc_prev = mdc;
    end
  end

  // fill expected image of one frame, returns its slot count
  function automatic int add_frame(input int base, input logic [1:0] st2,
      input logic [1:0] op2, input logic [4:0] phy, input logic [4:0] rg,
      input bit rd, input logic [15:0] dat, input bit err);
    logic [13:0] hdr = {st2, op2, phy, rg};
    int n = rd ? (err ? 79 : 64) : 65;
    for (int i = 0; i < n; i++) begin
      exp_o[base+i] = 1'b0;
      if (i < 32) begin exp_oe[base+i] = 1; exp_o[base+i] = 1; end
      else if (i < 46) begin exp_oe[base+i] = 1; exp_o[base+i] = hdr[45-i]; end
      else if (!rd && i == 46) begin exp_oe[base+i] = 1; exp_o[base+i] = 1; end
      else if (!rd && i == 47) exp_oe[base+i] = 1;
      else if (!rd && i < 64) begin exp_oe[base+i] = 1; exp_o[base+i] = dat[63-i]; end
      else exp_oe[base+i] = 0;
    end
    return n;
  endfunction

  task automatic run_txn(input logic [1:0] op, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] ca, input logic [15:0] wd,
      input logic [15:0] rdv, input bit ta, input bit poke);
    bit rd = (op == 2'd0) || (op == 2'd2);
    bit err = rd && ta && !cfg_ta_ignore[phy];
    logic [1:0] sop;
    string tg = op[1] ? "R3" : (rd ? "R6" : "R5");
    int b = 0, wait_n = 0;
    if (op[1]) begin
      b = add_frame(0, 2'b00, 2'b00, phy, rg, 0, ca, 0);
      rd_base = rd ? b : -1;
      exp_n = b + add_frame(b, 2'b00, rd ? 2'b11 : 2'b01, phy, rg, rd, wd, err);
    end else begin
      if (rd) sop = cfg_op_ovr ? cfg_c22_rd_op : 2'b10;
      else    sop = cfg_op_ovr ? cfg_c22_wr_op : 2'b01;
      rd_base = rd ? 0 : -1;
      exp_n = add_frame(0, 2'b01, sop, phy, rg, rd, wd, err);
    end
    ta_val = ta; rd_val = rdv;
    slot = 0; done_cnt = 0; half_bad = 0; seen_edge = 0; mdc_prev = 0; run_len = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
    req_op = op; req_phy = phy; req_reg = rg; req_c45_addr = ca; req_wdata = wd;
    req_valid = 1'b1; mon_en = 1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      req_valid = 1'b1; req_op = ~op; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
      repeat (30) @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_cnt == 0 && wait_n < 20000) begin @(negedge clk); wait_n++; end
    chk(!mdc && !mdio_oe && req_ready, "R9", "bus quiet at done", {mdc, mdio_oe, req_ready}, 3'b001);
    repeat (8) @(negedge clk);
    mon_en = 0; mdio_i = 1'b1;
    chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    chk(slot == exp_n, tg, "slot count", slot, exp_n);
    begin
      int first = -1;
      for (int i = 0; i < exp_n && i < 160; i++)
        if (cap_oe[i] != exp_oe[i] || (exp_oe[i] && cap_o[i] != exp_o[i]))
          if (first < 0) first = i;
      chk(first < 0, tg, "frame image first bad slot (R1 R2 R4)", first,
          -1);
    end
    chk(half_bad == 0, "R9", "half period errors", half_bad, 0);
    if (rd) begin
      chk(got_data == (err ? 16'hFFFF : rdv), err ? "R7" : (ta ? "R8" : "R6"),
          "rsp_data", got_data, err ? 16'hFFFF : rdv);
      chk(got_err == err, err ? "R7" : "R8", "rsp_ta_err", got_err, err);
    end
  endtask

  initial begin
    int seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mdc && !mdio_oe && !rsp_done, "R10", "reset state",
        {req_ready, mdc, mdio_oe, rsp_done}, 4'b1000);
    // directed corner cases (R11 op codes)
    run_txn(2'd0, 5'h11, 5'h0A, 16'h0, 16'h0, 16'hA5C3, 0, 0);
    run_txn(2'd1, 5'h05, 5'h1F, 16'h0, 16'h8001, 16'h0, 0, 0);
    run_txn(2'd2, 5'h1E, 5'h03, 16'hBEEF, 16'h0, 16'h1234, 0, 0);
    run_txn(2'd3, 5'h01, 5'h07, 16'h0F0F, 16'hC0DE, 16'h0, 0, 0);
    run_txn(2'd0, 5'h09, 5'h02, 16'h0, 16'h0, 16'h5555, 1, 0);        // R7
    cfg_ta_ignore = 32'h0000_0200;
    run_txn(2'd0, 5'h09, 5'h02, 16'h0, 16'h0, 16'h6B1D, 1, 0);        // R8
    run_txn(2'd2, 5'h04, 5'h02, 16'h0001, 16'h0, 16'hFFFE, 1, 0);     // R7 extended
    cfg_op_ovr = 1'b1; cfg_c22_rd_op = 2'b11; cfg_c22_wr_op = 2'b00;  // R2 override
    run_txn(2'd0, 5'h12, 5'h13, 16'h0, 16'h0, 16'h0F00, 0, 0);
    run_txn(2'd1, 5'h12, 5'h13, 16'h0, 16'h7E81, 16'h0, 0, 0);
    cfg_op_ovr = 1'b0;
    cfg_half_div = 8'd1;
    run_txn(2'd3, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 16'h0, 0, 1);     // R10 busy poke
    cfg_half_div = 8'd0;
    run_txn(2'd2, 5'h00, 5'h00, 16'h8000, 16'h0, 16'h0001, 0, 0);
    // constrained random
    for (int t = 0; t < 24; t++) begin
      cfg_half_div  = 8'($urandom_range(1, 5));
      cfg_ta_ignore = $urandom;
      cfg_op_ovr    = 1'($urandom_range(0, 1));
      cfg_c22_rd_op = 2'($urandom); cfg_c22_wr_op = 2'($urandom);
      run_txn(2'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
              16'($urandom), 16'($urandom), ($urandom_range(0, 3) == 0),
              ($urandom_range(0, 4) == 0));
    end
    if (seed == 0) n_chk = n_chk;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule